// File: doc/BRIEF.md
# Slotted p-persistent channel access arbiter

This block decides the moment at which a half-duplex radio link may begin to transmit. It uses slotted p-persistent carrier-sense access. A periodic tick, nominally every 10 ms, drives the evaluation. The evaluation runs only on ticks where the transmitter is idle and a frame is waiting.

While carrier is heard, the arbiter keeps its slot countdown full. While the channel is clear, it counts slots down. When a slot expires, it takes a random draw and allows transmission with a probability set by an 8-bit persistence value. In full-duplex mode it grants at once. The grant is a single-cycle start pulse for the transmit sequencer. A free-running LFSR inside the block supplies the random draws. Suggested settings are a slot time of 100 ms and a persistence of 64.

Top module: `pp_access_arbiter`

## Requirements
- R1: An evaluation happens only on a clock edge where `tick`, `frame_pending` and `tx_idle` are all high. `tx_start` is high for exactly the one cycle after an evaluating edge that grants, and low at every other time.
- R2: When `full_duplex` is high at an evaluation, the evaluation grants. Carrier, the slot counter and the random value are all ignored.
- R3: When `carrier` is high at a half-duplex evaluation, the slot counter is reloaded and no grant is issued.
- R4: At a half-duplex evaluation with carrier low and a slot counter above 1, the counter is decremented and no grant is issued. From a full counter of N ≥ 1, the N-th consecutive clear evaluation is the one that draws.
- R5: At a clear half-duplex evaluation with a counter of 1 or 0, the counter is reloaded and a draw is taken. The draw is bits [7:0] of the LFSR at that edge. The evaluation grants only if the draw is less than or equal to `persist`, so a `persist` of 255 always grants.
- R6: The reload value is `slot_ms` / 10, rounded down. A slot time below 20 ms therefore draws at every clear evaluation.
- R7: A change of `slot_ms` reloads the slot counter on the next clock edge.
- R8: After reset, `tx_start` is low and the slot counter is loaded from `slot_ms` on the first clock edge.
- R9: The LFSR resets to 16'hACE1. On every clock edge it shifts left, with bit0 taking lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]. It never holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per arbitration period |
| carrier | input | 1 | Carrier detected on the channel |
| frame_pending | input | 1 | A frame is waiting to be sent |
| tx_idle | input | 1 | Transmitter is idle |
| full_duplex | input | 1 | Skip channel access arbitration |
| slot_ms | input | SLOT_W | Slot time in milliseconds |
| persist | input | 8 | Persistence threshold, 0 to 255 |
| tx_start | output | 1 | One-cycle grant to begin transmission |

## Verification
Directed runs cover the following cases:
- A fully clear channel with a persistence of 255. This separates counting slots from drawing, because exactly the tenth tick must grant.
- Carrier arriving in the middle of a count. This shows that the countdown restarts rather than pauses.
- Full duplex with carrier present. This shows that carrier is ignored in that mode.
- Ticks without a pending frame, or with a busy transmitter. These show that the counter is left untouched.
- A short slot time and a change of slot time in the middle of a count. These cover the reload paths.

A long seeded random run then mixes carrier, mode, persistence and gating. A bench model of the LFSR and the counter compares the grant decision at every tick, which also tests the inclusive persistence threshold.

// File: rtl/pp_access_arbiter.sv
module pp_access_arbiter #(
  parameter int          SLOT_W    = 12,
  parameter int          TICK_MS   = 10,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              carrier,
  input  logic              frame_pending,
  input  logic              tx_idle,
  input  logic              full_duplex,
  input  logic [SLOT_W-1:0] slot_ms,
  input  logic [7:0]        persist,
  output logic              tx_start
);
  localparam int CNT_W = SLOT_W;

  logic [15:0]       lfsr;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  reload;
  logic [SLOT_W-1:0] slot_q;
  logic              loaded_q;
  logic              eval, clear, expire, reload_req, grant;

  assign reload     = CNT_W'(slot_ms / SLOT_W'(TICK_MS));
  assign eval       = tick && frame_pending && tx_idle;
  assign clear      = eval && !full_duplex && !carrier;
  assign expire     = clear && (cnt <= CNT_W'(1));
  assign reload_req = !loaded_q || (slot_ms != slot_q);
  assign grant      = eval && (full_duplex || (expire && (lfsr[7:0] <= persist)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= LFSR_SEED;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      slot_q   <= '0;
      loaded_q <= 1'b0;
      tx_start <= 1'b0;
    end else begin
      loaded_q <= 1'b1;
      slot_q   <= slot_ms;
      tx_start <= grant;
      if (reload_req)                                 cnt <= reload;
      else if (eval && !full_duplex && carrier)       cnt <= reload;
      else if (expire)                                cnt <= reload;
      else if (clear)                                 cnt <= cnt - CNT_W'(1);
    end
  end

  p_start_needs_eval_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(tick && frame_pending && tx_idle));

  p_duplex_grants_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && full_duplex) |=> tx_start);

  p_carrier_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !full_duplex && carrier) |=> !tx_start);

  p_carrier_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !full_duplex && carrier && !reload_req) |=> (cnt == $past(reload)));

  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && (cnt > CNT_W'(1)) && !reload_req) |=> (cnt == $past(cnt) - CNT_W'(1)) && !tx_start);

  p_persist_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !$past(full_duplex)) |-> ($past(lfsr[7:0]) <= $past(persist)));

  p_slot_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && (slot_ms != slot_q)) |=> (cnt == $past(reload)));

  p_lfsr_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0000);
endmodule

// File: tb/pp_access_arbiter_tb_top.sv
module pp_access_arbiter_tb_top;
  localparam int SLOT_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0, carrier = 1'b0, frame_pending = 1'b0, tx_idle = 1'b0, full_duplex = 1'b0;
  logic [SLOT_W-1:0] slot_ms = 12'd100;
  logic [7:0]        persist = 8'd64;
  logic              tx_start;

  int checks = 0;
  int errors = 0;
  logic [15:0]       m_lfsr;
  int                m_cnt;

  always #10 clk = ~clk;

  pp_access_arbiter #(.SLOT_W(SLOT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .carrier(carrier),
    .frame_pending(frame_pending), .tx_idle(tx_idle), .full_duplex(full_duplex),
    .slot_ms(slot_ms), .persist(persist), .tx_start(tx_start));

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic int reload_of(input logic [SLOT_W-1:0] s);
    return int'(s) / 10;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_lfsr <= 16'hACE1;
    else        m_lfsr <= lfsr_next(m_lfsr);

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: tx_start=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_slot(input logic [SLOT_W-1:0] s);
    slot_ms = s;
    m_cnt   = reload_of(s);
    @(negedge clk);
    check("R7", tx_start, 1'b0);
  endtask

  task automatic do_tick(input logic pend, input logic idle, input logic car, input logic fd);
    logic  exp;
    string req;
    frame_pending = pend; tx_idle = idle; carrier = car; full_duplex = fd;
    tick = 1'b1;
    exp = 1'b0; req = "R1";
    if (pend && idle) begin
      if (fd) begin
        exp = 1'b1; req = "R2";
      end else if (car) begin
        m_cnt = reload_of(slot_ms); req = "R3";
      end else if (m_cnt > 1) begin
        m_cnt--; req = "R4";
      end else begin
        m_cnt = reload_of(slot_ms);
        exp = (m_lfsr[7:0] <= persist); req = "R5";
      end
    end
    @(negedge clk);
    tick = 1'b0;
    check(req, tx_start, exp);
    @(negedge clk);
    check("R1", tx_start, 1'b0);
  endtask

  initial begin
    #(150000 * 20);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R8", tx_start, 1'b0);
    rst_n = 1'b1;
    m_cnt = reload_of(slot_ms);
    repeat (2) @(negedge clk);
    check("R8", tx_start, 1'b0);

    // R4/R6: clear channel, persist 255, tenth tick grants
    persist = 8'd255;
    for (int i = 0; i < 10; i++) do_tick(1, 1, 0, 0);
    // R3: carrier in mid-count restarts the countdown
    for (int i = 0; i < 5; i++) do_tick(1, 1, 0, 0);
    do_tick(1, 1, 1, 0);
    for (int i = 0; i < 10; i++) do_tick(1, 1, 0, 0);
    // R2: full duplex with carrier present
    do_tick(1, 1, 1, 1);
    do_tick(1, 1, 0, 1);
    // R1: gating leaves counter alone
    for (int i = 0; i < 3; i++) do_tick(1, 1, 0, 0);
    do_tick(0, 1, 0, 1);
    do_tick(1, 0, 0, 0);
    for (int i = 0; i < 7; i++) do_tick(1, 1, 0, 0);
    // R6: short slot draws every tick
    set_slot(12'd15);
    for (int i = 0; i < 4; i++) do_tick(1, 1, 0, 0);
    set_slot(12'd5);
    for (int i = 0; i < 4; i++) do_tick(1, 1, 0, 0);
    // R5: persist 0 grants only on draw 0
    persist = 8'd0;
    for (int i = 0; i < 40; i++) do_tick(1, 1, 0, 0);
    // R7: slot change mid-count reloads
    persist = 8'd255;
    set_slot(12'd100);
    for (int i = 0; i < 4; i++) do_tick(1, 1, 0, 0);
    set_slot(12'd30);
    for (int i = 0; i < 3; i++) do_tick(1, 1, 0, 0);

    // Random mix, R9 through the modelled draws
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 49) == 0) set_slot(SLOT_W'($urandom_range(0, 250)));
      persist = 8'($urandom_range(0, 255));
      do_tick($urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0,
              $urandom_range(0, 3) == 0, $urandom_range(0, 15) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule